// File: doc/BRIEF.md
# Pipelined Converter Redundant-Decision Combiner

This block forms the output word of one channel of a nine-stage pipelined analog-to-digital converter. Every stage but the last resolves its held input against two comparators and reports one of three decisions. The last stage is a four-level flash. A sample's decisions do not arrive together. The residue moves down the pipeline by one stage every half clock, and the block is clocked on the rising edge only, so two stage decisions for a sample arrive in each clock. The block delays the early stages so that all nine decisions of one sample meet in the same cycle. It then adds them, each stage weighted at half the weight of the stage before it. Adjacent weights overlap by one bit, so a wrong comparator decision in one stage is made up by the later stages. The result is a 10-bit offset-binary code in which no code is missing.

The analog stages feed `dec_i`, staggered the same way the pipeline produces them. The corrected code appears with a fixed latency, and `valid_o` marks the point after reset from which every code comes from decisions that were all captured after reset.

Top module: `pipe_adc_correct`

## Requirements
- R1: Stage k (k = 1..9) drives `dec_i[2k-1:2k-2]`. For stages 1 to 8 the decision values are 0 (below the lower comparator), 1 (between the comparators) and 2 (above the upper comparator). Stage 9 drives a flash code from 0 to 3.
- R2: The decisions of one sample come from stages 1 and 2 at some edge E, from stages 3 and 4 at E+1, from stages 5 and 6 at E+2, from stages 7 and 8 at E+3, and from stage 9 at E+4. The corrected code for that sample can be read on `code_o` immediately after edge E+4. Bit 0 of the code equals stage 9's bit 0 sampled at that edge.
- R3: The code is the sum over k = 1..8 of d_k·2^(9-k), plus the stage-9 code. All middle decisions (1) with a final code of 2 give mid-scale, 512 (10'b10_0000_0000).
- R4: The value 3 on any of stages 1 to 8 has the same effect as 2.
- R5: The code is limited to the range 0..1023. A sum above 1023 gives 1023. All-low decisions give 0. All-high decisions, including the value 3 on every stage, give 1023.
- R6: Take stages whose comparator thresholds are offset by up to ±3/16 of full scale and a final flash that is ideal. For an input at the centre of code n, the output is exactly n for every n from 0 to 1023, so no code is missing.
- R7: At any rising edge while `rst_n` is low, `code_o` becomes 0 and `valid_o` becomes 0.
- R8: `valid_o` stays low for the first four rising edges after reset is released. It rises at the fifth edge and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_i | input | 18 | Stage decisions, two bits per stage, stage 1 in the low bits |
| code_o | output | 10 | Corrected offset-binary code |
| valid_o | output | 1 | High once the alignment pipeline has filled after reset |

## Verification
The main check drives full 1024-code ramps through a behavioural model of the nine stages. The ramp is run once with ideal comparators, once with every threshold shifted up, once shifted down, and once with offsets that alternate from stage to stage. Only correct overlap correction returns every code exactly, so this pattern finds weighting and redundancy errors, and any code lost to an offset. Walking a single non-zero decision through each stage pins down the bit position and weight of each stage. Streams of mixed random decisions, presented back to back, expose any error in the stage alignment or the latency that a constant input would hide. Directed all-low, all-high and illegal-value vectors cover the saturation and the handling of the value 3.

// File: rtl/adc_corr_pkg.sv
// Shared types and helpers for the pipelined-converter decision combiner.
// Assumes every stage reports its decision on a two-bit field.
package adc_corr_pkg;

    localparam int DEC_W = 2;

    typedef logic [DEC_W-1:0] dec_t;

    // Maps the unused three-level code 3 onto the top decision 2.
    function automatic dec_t legalize(dec_t d);
        return (d == 2'd3) ? 2'd2 : d;
    endfunction

endpackage

// File: rtl/stage_skew.sv
// Delay line of DEPTH registers for one stage decision. A DEPTH of zero
// is a plain wire. Assumes synchronous active-low reset clears every tap.
module stage_skew #(
    parameter int W     = 2,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q_o = d_i;
        end else begin : g_regs
            logic [W-1:0] taps [DEPTH];

            // Shift the decision one tap further each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= d_i;
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end

            assign q_o = taps[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/overlap_adder.sv
// Adds the aligned stage decisions with weights that halve from stage to
// stage and saturates the sum to the output width. Stages before the last
// give three-level decisions, which are legalized here. The last stage's
// code is added at unit weight. Purely combinational.
module overlap_adder
    import adc_corr_pkg::*;
#(
    parameter int NUM_STAGES = 9,
    parameter int OUT_W      = NUM_STAGES + 1
) (
    input  logic [DEC_W*NUM_STAGES-1:0] aligned_i,
    output logic [OUT_W-1:0]            code_o
);

    localparam int SUM_W    = OUT_W + 1;
    localparam int MAX_CODE = (1 << OUT_W) - 1;

    logic [SUM_W-1:0] acc;

    // Weighted sum: stage k (0-based) has weight 2^(NUM_STAGES-1-k).
    always_comb begin
        acc = '0;
        for (int k = 0; k < NUM_STAGES - 1; k++) begin
            acc = acc + ({{(SUM_W-DEC_W){1'b0}}, legalize(aligned_i[DEC_W*k +: DEC_W])}
                         << (NUM_STAGES - 1 - k));
        end
        acc = acc + {{(SUM_W-DEC_W){1'b0}}, aligned_i[DEC_W*(NUM_STAGES-1) +: DEC_W]};
    end

    // Clamp anything beyond the top code.
    always_comb begin
        if (acc > SUM_W'(MAX_CODE)) code_o = '1;
        else                        code_o = acc[OUT_W-1:0];
    end

endmodule

// File: rtl/fill_tracker.sv
// Counts edges after reset and raises a sticky flag on edge FILL, the
// point where the alignment pipeline holds only post-reset decisions.
module fill_tracker #(
    parameter int FILL = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic valid_o
);

    localparam int CNT_W = $clog2(FILL + 1);

    logic [CNT_W-1:0] cnt;

    // Count to FILL, then hold, and set the flag on the FILL-th edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            valid_o <= 1'b0;
        end else begin
            if (cnt != CNT_W'(FILL)) cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(FILL - 1)) valid_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pipe_adc_correct.sv
// Digital correction for one channel of a redundant pipelined converter.
// Assumes stage decisions arrive two per rising edge, with stages 2g+1 and
// 2g+2 arriving g cycles after stages 1 and 2. Each stage is delayed so all
// decisions of a sample meet, then summed with overlapping weights, and the
// code is registered.
module pipe_adc_correct
    import adc_corr_pkg::*;
#(
    parameter int NUM_STAGES = 9,
    parameter int OUT_W      = NUM_STAGES + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEC_W*NUM_STAGES-1:0] dec_i,
    output logic [OUT_W-1:0]            code_o,
    output logic                        valid_o
);

    localparam int LAST_GRP = (NUM_STAGES - 1) / 2;

    logic [DEC_W*NUM_STAGES-1:0] aligned;
    logic [OUT_W-1:0]            code_c;

    generate
        for (genvar k = 0; k < NUM_STAGES; k++) begin : g_skew
            stage_skew #(
                .W     (DEC_W),
                .DEPTH (LAST_GRP - k / 2)
            ) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (dec_i[DEC_W*k +: DEC_W]),
                .q_o   (aligned[DEC_W*k +: DEC_W])
            );
        end
    endgenerate

    overlap_adder #(
        .NUM_STAGES (NUM_STAGES),
        .OUT_W      (OUT_W)
    ) u_add (
        .aligned_i (aligned),
        .code_o    (code_c)
    );

    // Register the corrected code.
    always_ff @(posedge clk) begin
        if (!rst_n) code_o <= '0;
        else        code_o <= code_c;
    end

    fill_tracker #(
        .FILL (LAST_GRP + 1)
    ) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/corr_checker.sv
// Properties of the decision combiner, bound to every instance of the top.
// Keeps its own count of edges since reset to time the valid flag.
module corr_checker #(
    parameter int NUM_STAGES = 9,
    parameter int OUT_W      = NUM_STAGES + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             last_lsb,
    input logic [OUT_W-1:0] code_o,
    input logic             valid_o
);

    localparam int FILL  = (NUM_STAGES - 1) / 2 + 1;
    localparam int CNT_W = $clog2(FILL + 1);

    logic [CNT_W-1:0] since;

    // Edges since reset release, saturating at FILL.
    always_ff @(posedge clk) begin
        if (!rst_n)                      since <= '0;
        else if (since != CNT_W'(FILL)) since <= since + 1'b1;
    end

    // R7
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && code_o == '0));

    // R8
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    // R8
    fill_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == (since == CNT_W'(FILL)));

    // R2
    last_stage_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (code_o[0] == $past(last_lsb)));

endmodule

bind pipe_adc_correct corr_checker #(
    .NUM_STAGES (NUM_STAGES),
    .OUT_W      (OUT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .last_lsb (dec_i[2*NUM_STAGES-2]),
    .code_o   (code_o),
    .valid_o  (valid_o)
);

// File: tb/sim_pipe_adc_correct.sv
`timescale 1ns/1ps
// Bench for the decision combiner: staggered stimulus streams, expected codes
// from arithmetic and from a behavioural model of the analog stages.
module sim_pipe_adc_correct;

    localparam int NS   = 9;
    localparam int OW   = 10;
    localparam int LAT  = 4;
    localparam int MAXS = 1100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2*NS-1:0] dec = '0;
    logic [OW-1:0] code;
    logic          valid;

    int checks = 0;
    int errors = 0;

    logic [1:0] dmem [0:MAXS-1][1:NS];
    int         emem [0:MAXS-1];
    int         nsamp;

    always #2.5 clk = ~clk;

    pipe_adc_correct u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_i   (dec),
        .code_o  (code),
        .valid_o (valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Arithmetic expectation (R3, R4, R5).
    function automatic int model(input int s);
        int acc = 0;
        for (int k = 1; k <= NS - 1; k++) begin
            int d = int'(dmem[s][k]);
            if (d == 3) d = 2;
            acc += d << (NS - k);
        end
        acc += int'(dmem[s][NS]);
        if (acc > 1023) acc = 1023;
        return acc;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        dec   = '0;
        repeat (3) @(negedge clk);
        check("R7 code", int'(code), 0);
        check("R7 valid", int'(valid), 0);
        rst_n = 1'b1;
    endtask

    // Stage k takes sample c - (k-1)/2 in cycle c; code for sample s is read after edge s+LAT.
    task automatic run_stream(input string req);
        do_reset();
        for (int c = 0; c <= nsamp + LAT; c++) begin
            for (int k = 1; k <= NS; k++) begin
                int s = c - (k - 1) / 2;
                dec[2*k-2 +: 2] = (s >= 0 && s < nsamp) ? dmem[s][k] : 2'd0;
            end
            @(negedge clk);
            if (c < LAT) check("R8 valid low", int'(valid), 0);
            else if (c == LAT || c == nsamp + LAT) check("R8 valid high", int'(valid), 1);
            if (c >= LAT && c - LAT < nsamp) check(req, int'(code), emem[c - LAT]);
        end
    endtask

    // Behavioural stages with threshold offsets; pattern picks the offsets (R6).
    task automatic gen_sweep(input int pattern);
        for (int n = 0; n < 1024; n++) begin
            real v = (real'(n) + 0.5) / 512.0 - 1.0;
            for (int k = 1; k <= NS - 1; k++) begin
                real off;
                int  d;
                case (pattern)
                    0:       off = 0.0;
                    1:       off = 0.1875;
                    2:       off = -0.1875;
                    default: off = (k % 2 == 0) ? 0.125 : -0.125;
                endcase
                if (v < -0.25 + off)     d = 0;
                else if (v >= 0.25 + off) d = 2;
                else                      d = 1;
                dmem[n][k] = 2'(d);
                v = 2.0 * v - real'(d - 1);
            end
            if (v < -0.5)      dmem[n][NS] = 2'd0;
            else if (v < 0.0)  dmem[n][NS] = 2'd1;
            else if (v < 0.5)  dmem[n][NS] = 2'd2;
            else               dmem[n][NS] = 2'd3;
            emem[n] = n;
        end
        nsamp = 1024;
    endtask

    task automatic put_uniform(input int idx, input logic [1:0] mid, input logic [1:0] last);
        for (int k = 1; k <= NS - 1; k++) dmem[idx][k] = mid;
        dmem[idx][NS] = last;
        emem[idx] = model(idx);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R3: mid-scale and mixed mid values
        put_uniform(0, 2'd1, 2'd2);
        put_uniform(1, 2'd1, 2'd0);
        put_uniform(2, 2'd1, 2'd3);
        nsamp = 3;
        check("R3 mid-scale model", emem[0], 512);
        run_stream("R3");

        // R1: walk a decision of 1 through each stage
        for (int w = 0; w < NS; w++) begin
            for (int k = 1; k <= NS; k++) dmem[w][k] = (k == w + 1) ? 2'd1 : 2'd0;
            emem[w] = (w == NS - 1) ? 1 : (1 << (NS - 1 - w));
        end
        nsamp = NS;
        run_stream("R1");

        // R5: extremes
        put_uniform(0, 2'd0, 2'd0);
        put_uniform(1, 2'd2, 2'd3);
        put_uniform(2, 2'd0, 2'd0);
        put_uniform(3, 2'd2, 2'd3);
        nsamp = 4;
        check("R5 top model", emem[1], 1023);
        run_stream("R5");

        // R4: illegal value 3 on the three-level stages
        put_uniform(0, 2'd3, 2'd3);
        for (int k = 1; k <= NS; k++) dmem[1][k] = (k == 1) ? 2'd3 : 2'd0;
        emem[1] = 512;
        for (int k = 1; k <= NS; k++) dmem[2][k] = (k == 4) ? 2'd3 : 2'd1;
        dmem[2][NS] = 2'd2;
        emem[2] = model(2);
        nsamp = 3;
        run_stream("R4");

        // R2: back-to-back mixed decisions stress alignment
        for (int s = 0; s < 300; s++) begin
            for (int k = 1; k <= NS; k++) dmem[s][k] = 2'($urandom_range(0, 3));
            emem[s] = model(s);
        end
        nsamp = 300;
        run_stream("R2");

        // R6: full ramps under four offset patterns
        for (int p = 0; p < 4; p++) begin
            gen_sweep(p);
            run_stream("R6");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule